// File: doc/BRIEF.md
# Triggered Multi-Window Sample Recorder

This block records short bursts of a sample stream into on-chip memory, in the way a logic analyser does. After the block is armed, each trigger starts a window of a fixed number of consecutive samples. These are written into the next free slot of a buffer that holds a fixed number of windows. Samples that arrive between windows are dropped. When the last slot has been filled, recording stops until the block is armed again.

Samples arrive on a valid/ready stream with the trigger as a sideband bit on the same beat. Ready is always high, so the block never applies back-pressure. A beat exists only on a clock edge where valid is high. Cycles with valid low are not samples: they do not advance a window and are never stored. Stored data is read back through a plain synchronous read port that takes an address and returns the word one cycle later. Window length (default 30), window count (default 10) and sample width are parameters.

Top module: `cap_window_capture`

## Requirements
- R1: After reset the window count is 0 and the capturing and full flags are low. Until arm is pulsed, triggers start no window and nothing is stored.
- R2: A cycle with arm high clears the window count and the full flag, drops any window that is part way through, and enables capture. Arm takes priority over a beat on the same edge.
- R3: While armed and not full, a beat with trigger high starts a window, and that beat is the window's first sample. Window k (0-based) occupies addresses k*W to k*W+W-1, where W is the window length.
- R4: A window holds W consecutive beats. Cycles with valid low inside a window are not stored and do not advance the window. Ready is always 1.
- R5: A trigger on a beat inside an open window is ignored. It neither restarts nor extends that window.
- R6: Beats outside a window are discarded and overwrite no buffer location.
- R7: The capturing flag is high from the edge that stores a window's first sample until the edge that stores its last sample. The window count increases by one on the edge that stores the last sample.
- R8: The full flag rises on the edge that stores the last sample of the final window and stays high until the next arm. While it is high, no location is written and triggers are ignored.
- R9: Read data equals the word stored at the read address presented on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| arm | input | 1 | Clear counters and enable capture |
| smp_valid | input | 1 | Sample beat present |
| smp_ready | output | 1 | Always 1; the block never stalls |
| smp_trig | input | 1 | Trigger qualifier for this beat |
| smp_data | input | DW | Sample word |
| rd_addr | input | AW | Buffer read address |
| rd_data | output | DW | Word at rd_addr, one cycle later |
| win_count | output | CW | Number of complete windows stored |
| capturing | output | 1 | A window is open |
| full | output | 1 | All windows stored, capture halted |

## Verification
On every cycle, the assertions check these properties:
- Arm clears the count and the full flag.
- The count never exceeds the window total and moves by at most one per edge.
- Full stays high until arm.
- No write happens while full, and every write address lies inside the buffer.

Other behaviour can only be shown by the bench's scenarios:
- Each window starts on its trigger beat and lands at its own base address.
- Bubbles and triggers inside a window change nothing.
- Data between windows never reaches memory.

The bench shows these by comparing the whole buffer with its own model after uneven trigger spacing.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CAPT  = 2'd2,
    ST_FULL  = 2'd3
  } cap_state_e;
endpackage

// File: rtl/cap_addr_gen.sv
module cap_addr_gen #(
  parameter int WIN_LEN = 30,
  parameter int DEPTH   = 300,
  parameter int AW      = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  output logic [AW-1:0] wr_addr,
  output logic          off_last
);
  localparam int OW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [OW-1:0] OFF_MAX = OW'(WIN_LEN - 1);

  logic [OW-1:0] off_q;
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      off_q <= '0;
      ptr_q <= '0;
    end else if (step) begin
      ptr_q <= ptr_q + 1'b1;
      off_q <= (off_q == OFF_MAX) ? '0 : off_q + 1'b1;
    end
  end

  assign wr_addr  = ptr_q;
  assign off_last = (off_q == OFF_MAX);

  // R3: every write stays inside the buffer
  p_addr_in_range_r3: assert property (@(posedge clk) disable iff (rst)
    step |-> (int'(ptr_q) < DEPTH));
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int WIN_NUM = 10,
  parameter int CW      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          beat,
  input  logic          trig,
  input  logic          off_last,
  output logic          wr_en,
  output logic [CW-1:0] win_count,
  output logic          capturing,
  output logic          full
);
  localparam logic [CW-1:0] LAST_WIN = CW'(WIN_NUM - 1);

  cap_state_e st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic start, last;

  assign start = (st_q == ST_ARMED) && beat && trig && !arm;
  assign wr_en = !arm && (start || ((st_q == ST_CAPT) && beat));
  assign last  = wr_en && off_last;

  always_comb begin
    st_d = st_q;
    if (arm)
      st_d = ST_ARMED;
    else if (last)
      st_d = (cnt_q == LAST_WIN) ? ST_FULL : ST_ARMED;
    else if (start)
      st_d = ST_CAPT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (arm)
        cnt_q <= '0;
      else if (last)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign win_count = cnt_q;
  assign capturing = (st_q == ST_CAPT);
  assign full      = (st_q == ST_FULL);

  p_arm_clears_r2: assert property (@(posedge clk) disable iff (rst)
    arm |=> (win_count == '0) && !full);
  p_full_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (full && !arm) |=> full);
  p_no_write_full_r8: assert property (@(posedge clk) disable iff (rst)
    full |-> !wr_en);
  p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
    int'(win_count) <= WIN_NUM);
  p_count_step_r7: assert property (@(posedge clk) disable iff (rst)
    !arm |=> (win_count == $past(win_count)) ||
             (win_count == $past(win_count) + 1'b1));
endmodule

// File: rtl/cap_mem.sv
module cap_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 300,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= ram[raddr];
  end
endmodule

// File: rtl/cap_window_capture.sv
module cap_window_capture #(
  parameter int DW      = 8,
  parameter int WIN_LEN = 30,
  parameter int WIN_NUM = 10,
  localparam int DEPTH  = WIN_LEN * WIN_NUM,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW     = $clog2(WIN_NUM + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic          smp_trig,
  input  logic [DW-1:0] smp_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] win_count,
  output logic          capturing,
  output logic          full
);
  logic          wr_en;
  logic          off_last;
  logic [AW-1:0] wr_addr;

  assign smp_ready = 1'b1;

  cap_ctrl #(.WIN_NUM(WIN_NUM), .CW(CW)) u_ctrl (
    .clk, .rst, .arm,
    .beat      (smp_valid),
    .trig      (smp_trig),
    .off_last  (off_last),
    .wr_en     (wr_en),
    .win_count (win_count),
    .capturing (capturing),
    .full      (full)
  );

  cap_addr_gen #(.WIN_LEN(WIN_LEN), .DEPTH(DEPTH), .AW(AW)) u_addr (
    .clk, .rst,
    .clr      (arm),
    .step     (wr_en),
    .wr_addr  (wr_addr),
    .off_last (off_last)
  );

  cap_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk, .rst,
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (smp_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  // R1: nothing opens before the first arm after reset
  p_idle_after_reset_r1: assert property (@(posedge clk)
    rst |=> (win_count == '0) && !capturing && !full);
endmodule

// File: tb/cap_window_capture_tb.sv
`timescale 1ns/1ps
module cap_window_capture_tb;
  localparam int DW = 8, W = 5, N = 4;
  localparam int DEPTH = W * N;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(N + 1);
  // gap beats before trigger, bubble inside window, retrigger inside window
  localparam int TBL [N][3] = '{'{2, 0, 0}, '{0, 1, 0}, '{5, 0, 1}, '{1, 1, 1}};

  logic clk = 0, rst = 1, arm = 0, smp_valid = 0, smp_trig = 0;
  logic [DW-1:0] smp_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic smp_ready, capturing, full;
  logic [DW-1:0] rd_data;
  logic [CW-1:0] win_count;

  int total = 0, bad = 0;
  bit done = 0;
  logic [DW-1:0] exp_mem [DEPTH];
  bit m_armed = 0, m_inwin = 0, m_full = 0;
  int m_off = 0, m_ptr = 0, m_cnt = 0;
  logic [DW-1:0] dval = 8'h10;

  always #5 clk = ~clk;

  cap_window_capture #(.DW(DW), .WIN_LEN(W), .WIN_NUM(N)) u_dut (
    .clk, .rst, .arm, .smp_valid, .smp_ready, .smp_trig, .smp_data,
    .rd_addr, .rd_data, .win_count, .capturing, .full);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic status(string req);
    chk({req, " count"}, int'(win_count), m_cnt);
    chk({req, " capturing"}, int'(capturing), int'(m_inwin));
    chk({req, " full"}, int'(full), int'(m_full));
  endtask

  task automatic beat(bit v, bit t);
    @(negedge clk);
    smp_valid = v; smp_trig = t; smp_data = dval;
    if (m_armed && !m_full && v && (m_inwin || t)) begin
      exp_mem[m_ptr] = dval;
      m_ptr++;
      if (m_off == W - 1) begin
        m_off = 0; m_inwin = 0; m_cnt++;
        if (m_cnt == N) m_full = 1;
      end else begin
        m_off++; m_inwin = 1;
      end
    end
    dval = dval + 8'd1;
    @(posedge clk); #1;
  endtask

  task automatic do_arm();
    @(negedge clk);
    arm = 1; smp_valid = 1; smp_trig = 1; smp_data = 8'hEE;
    m_armed = 1; m_inwin = 0; m_full = 0; m_off = 0; m_ptr = 0; m_cnt = 0;
    @(posedge clk); #1;
    @(negedge clk); arm = 0; smp_valid = 0; smp_trig = 0;
  endtask

  task automatic rd(int a, string req);
    @(negedge clk); rd_addr = AW'(a);
    @(posedge clk); #1;
    chk(req, int'(rd_data), int'(exp_mem[a]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    status("R1 reset");
    chk("R4 ready", int'(smp_ready), 1);
    beat(1, 1); beat(1, 1);
    status("R1 trigger before arm");

    do_arm();
    status("R2 after arm");
    chk("R2 arm beat not a window", int'(capturing), 0);

    for (int i = 0; i < N; i++) begin
      for (int g = 0; g < TBL[i][0]; g++) beat(1, 0); // R6 discarded beats
      beat(1, 1);
      status("R3 window start");
      chk("R7 capturing after trigger", int'(capturing), 1);
      for (int j = 1; j < W; j++) begin
        if (TBL[i][1] != 0 && j == 2) begin
          beat(0, 1);
          status("R4 bubble");
        end
        beat(1, (TBL[i][2] != 0 && j == 1) ? 1'b1 : 1'b0);
      end
      status("R7 window end"); // R5 retrigger did not extend
      chk("R7 count", int'(win_count), i + 1);
    end
    chk("R8 full", int'(full), 1);

    beat(1, 1); beat(1, 0); beat(1, 1);
    status("R8 after full");
    for (int a = 0; a < DEPTH; a++) rd(a, "R9 R3 R6 readback");

    do_arm();
    status("R2 re-arm");
    chk("R2 full cleared", int'(full), 0);
    beat(1, 0);
    beat(1, 1);
    for (int j = 1; j < W; j++) beat(1, 0);
    status("R3 first window after re-arm");
    rd(0, "R3 base after re-arm");
    rd(W - 1, "R9 last of window");

    do_arm();
    beat(1, 1); beat(1, 0);
    do_arm();
    status("R2 arm drops open window");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule